// File: doc/BRIEF.md
# Privilege Mode and Trap Entry Unit

This unit owns the processor's privilege bit, the active stack pointer and the program-counter redirect for every control transfer into and out of the kernel. Privilege is a single bit: 0 means untrusted user code and 1 means trusted kernel code. Several events move control into the kernel: leaving reset, a system-call instruction, a synchronous exception, a maskable interrupt, or a privileged operation attempted from user mode. On any of these except reset, one clock edge captures the user context (stack pointer, program counter, privilege bit) into a single set of shadow registers. The same edge switches the stack to the kernel stack, sets the privilege bit, and records a cause code where the event has one.

The core presents the current PC every cycle. It also presents stack-pointer writes and single-cycle strobes for the events. The unit answers in the same cycle with the next PC and a redirect flag. System calls enter at one fixed vector. Interrupts, exceptions and privilege faults enter at a second fixed vector. A return-from-trap strobe issued in kernel mode restores the saved privilege bit and stack pointer and redirects to the saved PC. Instruction decode and the general register file stay in the core.

Top module: `trap_unit`

## Requirements
- R1: After reset the privilege bit is 1, the stack pointer equals KSTACK_TOP and the cause is 0. The shadow state is PC 0, SP 0, privilege 0. In the first cycle after reset is released, redirect_o is 1 and pc_o equals BOOT_ADDR, and no other event is taken in that cycle.
- R2: A system call sets redirect_o to 1 and pc_o to SYSCALL_VEC in the same cycle. From the next cycle the privilege bit is 1 and sp_o equals KSTACK_TOP. The saved PC is pc_i + INSN_BYTES and the cause is left unchanged.
- R3: An exception sets pc_o to TRAP_VEC in the same cycle. From the next cycle cause_o holds exc_cause_i, and the saved PC is pc_i of the faulting instruction.
- R4: A return-from-trap in kernel mode sets pc_o to the saved PC with redirect_o 1. From the next cycle the privilege bit and sp_o take their saved values, which may be the kernel privilege when the trap was taken from kernel mode.
- R5: A privileged operation (priv_op_i) in user mode is not performed. It raises priv_fault_o and traps to TRAP_VEC, and cause_o becomes PRIV_CAUSE. In kernel mode, priv_op_i raises no fault and no redirect.
- R6: A return-from-trap issued in user mode is treated as a privilege fault. It redirects to TRAP_VEC, not to the saved PC, and sets cause PRIV_CAUSE.
- R7: When an interrupt and a system call arrive together in user mode, the interrupt is taken and cause_o becomes irq_cause_i. The saved PC is the system call's own PC, so the system call is retried after the return.
- R8: While the privilege bit is 1, irq_i has no effect on pc_o, redirect_o or cause_o. A pending irq_i is taken in the first user-mode cycle after the return-from-trap.
- R9: The fixed priority order is: interrupt (user mode only), then exception, then privilege fault, then system call, then return-from-trap. An exception together with a system call takes the exception.
- R10: sp_we_i loads sp_i into sp_o on the next cycle, unless a trap or a return-from-trap is taken in the same cycle. Those take precedence.
- R11: With no event, redirect_o is 0 and pc_o equals pc_i + INSN_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | XLEN | PC of the instruction in the current cycle |
| sp_i | input | XLEN | Stack-pointer write data |
| sp_we_i | input | 1 | Stack-pointer write enable |
| syscall_i | input | 1 | System-call instruction strobe |
| exc_i | input | 1 | Synchronous exception strobe |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| irq_i | input | 1 | Maskable interrupt request |
| irq_cause_i | input | CAUSE_W | Interrupt cause code |
| priv_op_i | input | 1 | Privileged operation attempted |
| eret_i | input | 1 | Return-from-trap strobe |
| pc_o | output | XLEN | Next PC |
| redirect_o | output | 1 | pc_o is a control transfer, not sequential |
| sp_o | output | XLEN | Active stack pointer |
| mode_o | output | 1 | Privilege bit (1 = kernel) |
| cause_o | output | CAUSE_W | Cause of the last interrupt or exception |
| priv_fault_o | output | 1 | Privilege fault taken this cycle |

## Verification
The bench builds the unit with its default parameters. These are a 32-bit datapath, 4-byte instructions, boot address 0x100, system-call vector 0x200, trap vector 0x300, kernel stack 0xF000 and privilege-fault cause 0xF. With these values the two vectors, the boot address and every return address can be told apart in one comparison. The bench also exercises a nested trap from kernel mode, which shows that the saved privilege bit, and not a constant, is what the return restores.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_BOOT,
    EV_IRQ,
    EV_EXC,
    EV_PRIV,
    EV_SYSCALL,
    EV_ERET
  } trap_ev_e;
endpackage

// File: rtl/trap_arbiter.sv
`timescale 1ns/1ps
module trap_arbiter
  import trap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     boot_i,
  input  logic     mode_i,
  input  logic     irq_i,
  input  logic     exc_i,
  input  logic     priv_op_i,
  input  logic     syscall_i,
  input  logic     eret_i,
  output trap_ev_e ev_o,
  output logic     priv_fault_o
);
  logic user_priv_viol;

  // return-from-trap is itself privileged
  assign user_priv_viol = !mode_i && (priv_op_i || eret_i);

  always_comb begin
    if (boot_i)                  ev_o = EV_BOOT;
    else if (irq_i && !mode_i)   ev_o = EV_IRQ;
    else if (exc_i)              ev_o = EV_EXC;
    else if (user_priv_viol)     ev_o = EV_PRIV;
    else if (syscall_i)          ev_o = EV_SYSCALL;
    else if (eret_i && mode_i)   ev_o = EV_ERET;
    else                         ev_o = EV_NONE;
  end

  assign priv_fault_o = (ev_o == EV_PRIV);

  // R8: interrupts never taken in kernel mode
  a_r8_irq_masked_in_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o == EV_IRQ) |-> !mode_i);

  // R6: user-mode return becomes a privilege fault when nothing outranks it
  a_r6_user_eret_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !mode_i && !boot_i && !irq_i && !exc_i) |-> priv_fault_o);
endmodule

// File: rtl/trap_ctx.sv
`timescale 1ns/1ps
module trap_ctx
  import trap_pkg::*;
#(
  parameter int                XLEN       = 32,
  parameter int                CAUSE_W    = 4,
  parameter int                INSN_BYTES = 4,
  parameter logic [XLEN-1:0]   KSTACK_TOP = 32'h0000_F000,
  parameter logic [CAUSE_W-1:0] PRIV_CAUSE = 4'hF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  trap_ev_e           ev_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    sp_i,
  input  logic               sp_we_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [CAUSE_W-1:0] irq_cause_i,
  output logic               boot_o,
  output logic               mode_o,
  output logic [XLEN-1:0]    sp_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    saved_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic               boot_q, mode_q, saved_mode_q;
  logic [XLEN-1:0]    sp_q, saved_sp_q, saved_pc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               is_trap;

  assign is_trap = (ev_i == EV_IRQ) || (ev_i == EV_EXC) ||
                   (ev_i == EV_PRIV) || (ev_i == EV_SYSCALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q       <= 1'b1;
      mode_q       <= 1'b1;
      sp_q         <= KSTACK_TOP;
      cause_q      <= '0;
      saved_mode_q <= 1'b0;
      saved_sp_q   <= '0;
      saved_pc_q   <= '0;
    end else begin
      boot_q <= 1'b0;
      if (is_trap) begin
        saved_mode_q <= mode_q;
        saved_sp_q   <= sp_q;
        // syscall returns past itself; others re-run the interrupted insn
        saved_pc_q   <= (ev_i == EV_SYSCALL) ? pc_i + STEP : pc_i;
        mode_q       <= 1'b1;
        sp_q         <= KSTACK_TOP;
        case (ev_i)
          EV_IRQ:  cause_q <= irq_cause_i;
          EV_EXC:  cause_q <= exc_cause_i;
          EV_PRIV: cause_q <= PRIV_CAUSE;
          default: cause_q <= cause_q;
        endcase
      end else if (ev_i == EV_ERET) begin
        mode_q <= saved_mode_q;
        sp_q   <= saved_sp_q;
      end else if (sp_we_i) begin
        sp_q <= sp_i;
      end
    end
  end

  assign boot_o     = boot_q;
  assign mode_o     = mode_q;
  assign sp_o       = sp_q;
  assign cause_o    = cause_q;
  assign saved_pc_o = saved_pc_q;

  // R2: every trap lands in kernel mode on the kernel stack
  a_r2_trap_enters_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_trap |=> (mode_q && sp_q == KSTACK_TOP));

  // R4: return restores the captured context
  a_r4_eret_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_ERET) |=> (mode_q == $past(saved_mode_q) && sp_q == $past(saved_sp_q)));

  // R2: syscall leaves cause alone
  a_r2_syscall_keeps_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_SYSCALL) |=> $stable(cause_q));
endmodule

// File: rtl/trap_redirect.sv
`timescale 1ns/1ps
module trap_redirect
  import trap_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] BOOT_ADDR   = 32'h0000_0100,
  parameter logic [XLEN-1:0] SYSCALL_VEC = 32'h0000_0200,
  parameter logic [XLEN-1:0] TRAP_VEC    = 32'h0000_0300
) (
  input  trap_ev_e        ev_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] saved_pc_i,
  output logic [XLEN-1:0] pc_o,
  output logic            redirect_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    redirect_o = 1'b1;
    unique case (ev_i)
      EV_BOOT:                 pc_o = BOOT_ADDR;
      EV_SYSCALL:              pc_o = SYSCALL_VEC;
      EV_IRQ, EV_EXC, EV_PRIV: pc_o = TRAP_VEC;
      EV_ERET:                 pc_o = saved_pc_i;
      default: begin
        pc_o       = pc_i + STEP;
        redirect_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/trap_unit.sv
`timescale 1ns/1ps
module trap_unit
  import trap_pkg::*;
#(
  parameter int                 XLEN        = 32,
  parameter int                 CAUSE_W     = 4,
  parameter int                 INSN_BYTES  = 4,
  parameter logic [XLEN-1:0]    BOOT_ADDR   = 32'h0000_0100,
  parameter logic [XLEN-1:0]    SYSCALL_VEC = 32'h0000_0200,
  parameter logic [XLEN-1:0]    TRAP_VEC    = 32'h0000_0300,
  parameter logic [XLEN-1:0]    KSTACK_TOP  = 32'h0000_F000,
  parameter logic [CAUSE_W-1:0] PRIV_CAUSE  = 4'hF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    sp_i,
  input  logic               sp_we_i,
  input  logic               syscall_i,
  input  logic               exc_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_i,
  input  logic [CAUSE_W-1:0] irq_cause_i,
  input  logic               priv_op_i,
  input  logic               eret_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    sp_o,
  output logic               mode_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               priv_fault_o
);
  trap_ev_e        ev;
  logic            boot;
  logic [XLEN-1:0] saved_pc;

  trap_arbiter u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .boot_i       (boot),
    .mode_i       (mode_o),
    .irq_i        (irq_i),
    .exc_i        (exc_i),
    .priv_op_i    (priv_op_i),
    .syscall_i    (syscall_i),
    .eret_i       (eret_i),
    .ev_o         (ev),
    .priv_fault_o (priv_fault_o)
  );

  trap_ctx #(
    .XLEN       (XLEN),
    .CAUSE_W    (CAUSE_W),
    .INSN_BYTES (INSN_BYTES),
    .KSTACK_TOP (KSTACK_TOP),
    .PRIV_CAUSE (PRIV_CAUSE)
  ) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .sp_we_i     (sp_we_i),
    .exc_cause_i (exc_cause_i),
    .irq_cause_i (irq_cause_i),
    .boot_o      (boot),
    .mode_o      (mode_o),
    .sp_o        (sp_o),
    .cause_o     (cause_o),
    .saved_pc_o  (saved_pc)
  );

  trap_redirect #(
    .XLEN        (XLEN),
    .INSN_BYTES  (INSN_BYTES),
    .BOOT_ADDR   (BOOT_ADDR),
    .SYSCALL_VEC (SYSCALL_VEC),
    .TRAP_VEC    (TRAP_VEC)
  ) u_redir (
    .ev_i       (ev),
    .pc_i       (pc_i),
    .saved_pc_i (saved_pc),
    .pc_o       (pc_o),
    .redirect_o (redirect_o)
  );

  // R5: a privilege fault always redirects to the trap vector
  a_r5_fault_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault_o |-> (redirect_o && pc_o == TRAP_VEC));

  // R5: no fault can be raised from kernel mode
  a_r5_no_fault_in_kernel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> !priv_fault_o);
endmodule

// File: tb/trap_unit_bench.sv
`timescale 1ns/1ps
module trap_unit_bench;
  localparam logic [31:0] BOOT = 32'h100, SVEC = 32'h200, TVEC = 32'h300;
  localparam logic [31:0] KSP  = 32'hF000;
  localparam logic [3:0]  PCAUSE = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pc, sp_wd;
  logic sp_we, sys, exc, irq, pop, eret;
  logic [3:0] exc_c, irq_c;
  logic [31:0] pc_o, sp_o;
  logic redir, mode, pfault;
  logic [3:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_unit u_trap_unit (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .sp_i(sp_wd), .sp_we_i(sp_we),
    .syscall_i(sys), .exc_i(exc), .exc_cause_i(exc_c), .irq_i(irq),
    .irq_cause_i(irq_c), .priv_op_i(pop), .eret_i(eret), .pc_o(pc_o),
    .redirect_o(redir), .sp_o(sp_o), .mode_o(mode), .cause_o(cause),
    .priv_fault_o(pfault)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    sys = 0; exc = 0; irq = 0; pop = 0; eret = 0; sp_we = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // kernel return, checking pc and resulting mode/sp
  task automatic do_eret(string req, logic [31:0] exp_pc, logic exp_mode, logic [31:0] exp_sp);
    idle(); eret = 1; #1;
    chk({req, " eret redirect"}, redir, 1);
    chk({req, " eret pc"}, pc_o, exp_pc);
    tick(); idle();
    chk({req, " eret mode"}, mode, exp_mode);
    chk({req, " eret sp"}, sp_o, exp_sp);
  endtask

  task automatic t_reset();
    idle(); pc = 0; sp_wd = 0; exc_c = 0; irq_c = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    chk("R1 boot redirect", redir, 1);
    chk("R1 boot pc", pc_o, BOOT);
    chk("R1 mode", mode, 1);
    chk("R1 sp", sp_o, KSP);
    chk("R1 cause", cause, 0);
    tick();
  endtask

  task automatic t_sequential();
    idle(); pc = 32'h400; #1;
    chk("R11 no redirect", redir, 0);
    chk("R11 next pc", pc_o, 32'h404);
    tick();
    do_eret("R1 R4 first user entry", 32'h0, 0, 32'h0);
  endtask

  task automatic t_sp_write();
    idle(); pc = 32'h0; sp_we = 1; sp_wd = 32'h8000; tick(); idle();
    chk("R10 sp write", sp_o, 32'h8000);
  endtask

  task automatic t_syscall();
    idle(); pc = 32'h40; sys = 1; sp_we = 1; sp_wd = 32'h1234; #1;
    chk("R2 redirect", redir, 1);
    chk("R2 vector", pc_o, SVEC);
    tick(); idle();
    chk("R2 mode", mode, 1);
    chk("R10 trap beats sp write", sp_o, KSP);
    chk("R2 cause unchanged", cause, 0);
    // R8: interrupt held while in kernel
    pc = 32'h204; irq = 1; irq_c = 4'h3; #1;
    chk("R8 irq ignored redirect", redir, 0);
    chk("R8 irq ignored pc", pc_o, 32'h208);
    tick();
    chk("R8 cause unchanged", cause, 0);
    eret = 1; #1;
    chk("R2 return pc", pc_o, 32'h44);
    tick(); eret = 0;
    chk("R4 mode restored", mode, 0);
    chk("R4 sp restored", sp_o, 32'h8000);
    // R8: pending irq now taken
    pc = 32'h44; #1;
    chk("R8 deferred irq taken", pc_o, TVEC);
    tick(); idle();
    chk("R8 irq cause", cause, 4'h3);
    do_eret("R8", 32'h44, 0, 32'h8000);
  endtask

  task automatic t_exc_over_sys();
    idle(); pc = 32'h80; exc = 1; exc_c = 4'h5; sys = 1; #1;
    chk("R9 exc beats syscall", pc_o, TVEC);
    tick(); idle();
    chk("R3 cause", cause, 4'h5);
    do_eret("R3 faulting pc", 32'h80, 0, 32'h8000);
  endtask

  task automatic t_irq_sys();
    idle(); pc = 32'h90; irq = 1; irq_c = 4'h2; sys = 1; #1;
    chk("R7 irq taken", pc_o, TVEC);
    tick(); idle();
    chk("R7 cause", cause, 4'h2);
    do_eret("R7 syscall retried", 32'h90, 0, 32'h8000);
  endtask

  task automatic t_priv();
    idle(); pc = 32'hA0; pop = 1; #1;
    chk("R5 fault flag", pfault, 1);
    chk("R5 vector", pc_o, TVEC);
    tick(); idle();
    chk("R5 cause", cause, PCAUSE);
    chk("R5 mode", mode, 1);
    pc = 32'h300; pop = 1; #1;
    chk("R5 kernel no fault", pfault, 0);
    chk("R5 kernel no redirect", redir, 0);
    tick(); idle();
    do_eret("R5", 32'hA0, 0, 32'h8000);
  endtask

  task automatic t_user_eret();
    idle(); pc = 32'hB0; eret = 1; #1;
    chk("R6 fault flag", pfault, 1);
    chk("R6 vector not saved pc", pc_o, TVEC);
    tick(); idle();
    chk("R6 cause", cause, PCAUSE);
    chk("R6 mode", mode, 1);
    do_eret("R6", 32'hB0, 0, 32'h8000);
  endtask

  task automatic t_nested();
    idle(); pc = 32'hC0; sys = 1; tick(); idle();
    pc = 32'h210; exc = 1; exc_c = 4'h6; #1;
    chk("R3 kernel exc vector", pc_o, TVEC);
    tick(); idle();
    chk("R3 kernel exc cause", cause, 4'h6);
    do_eret("R4 nested keeps kernel", 32'h210, 1, KSP);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequential();
    t_sp_write();
    t_syscall();
    t_exc_over_sys();
    t_irq_sys();
    t_priv();
    t_user_eret();
    t_nested();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule